// File: doc/BRIEF.md
# Memory Region Attribute Matcher

This block classifies each bus access by address region and returns the attributes that software attached to that region. It holds four 32-bit region registers. Each register names an 8-bit base for the top address byte, an 8-bit don't-care mask over that byte, an enable, and a set of attribute fields: a two-bit cache mode, a two-bit supervisor-mode field, an addressing-mode bit and a write-protect bit.

Registers 0 and 1 serve data accesses, and registers 2 and 3 serve instruction fetches. Within each pair the lower-numbered register wins when both match. A one-bit access-kind input picks the pair to search. The lookup is purely combinational: the hit flag, the winning index and the attribute fields are valid in the same cycle as the address. Software reaches the registers through a small port. The port selects a register by a 12-bit register number and always moves a full 32-bit word.

Top module: `region_attr_matcher`

## Requirements
- R1: After a synchronous reset, all four registers read 0, and no access of either kind produces a hit.
- R2: Register numbers 0x004, 0x005, 0x006 and 0x007 select registers 0 to 3. A write is visible on the read port from the next cycle. The read port is combinational. A write to any other number changes nothing, and a read of any other number returns 0.
- R3: Only these bits store data: 31:16, 15, 14:13, 10, 6:5 and 2. All other bits read back 0. So writing all ones reads back 0xFFFFE464 in registers 0 and 1, and 0xFFFFE460 in registers 2 and 3.
- R4: Register layout: base in bits 31:24, mask in bits 23:16, enable in bit 15. A register matches when enable is 1 and ((address[31:24] XOR base) AND NOT mask) equals 0. Address bits 23:0 never affect matching.
- R5: A register whose enable bit is 0 never matches, and its attributes never reach the outputs.
- R6: A data access (acc_is_ifetch = 0) can be claimed only by registers 0 and 1. An instruction fetch (acc_is_ifetch = 1) can be claimed only by registers 2 and 3.
- R7: When both registers of the searched pair match, register 0 wins for data and register 2 wins for fetches.
- R8: On a hit, hit = 1 and hit_idx is the winner's number. The attribute outputs carry the winner's fields in the same cycle: cache mode from bits 6:5, supervisor mode from bits 14:13, addressing mode from bit 10 and write protect from bit 2. On a miss, hit, hit_idx and all attribute outputs are 0.
- R9: Several mask bits set at once, including bits that are not adjacent, let one register claim several separate 16 MB regions.
- R10: Bit 2 is write protect. It reads as 0 in registers 2 and 3, and it never drives attr_wprot on an instruction fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_num | input | 12 | Register number for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| acc_addr | input | 32 | Address of the current access |
| acc_is_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| hit | output | 1 | Some enabled register of the searched pair matches |
| hit_idx | output | 2 | Number of the winning register |
| attr_cmode | output | 2 | Winner's cache mode |
| attr_smode | output | 2 | Winner's supervisor-mode field |
| attr_amode | output | 1 | Winner's addressing-mode bit |
| attr_wprot | output | 1 | Winner's write-protect bit |

## Verification
The bench sets up overlapping regions in both pairs. A design with the priority reversed would report register 1 or 3 where 0 or 2 is expected. It probes addresses that differ only in masked bits or only in unmasked bits, and it uses a mask with separated bits. A design that treated the mask as a simple size, or inverted its sense, would miss or claim the wrong regions. It sends a data access into a region that only an instruction register covers, which catches a design that searched all four registers. It also clears enable bits, writes to unassigned register numbers, and writes all ones to check the zero bits and the instruction write-protect bit. A design that leaked a disabled register, stored stray bits or decoded register numbers too loosely would show a wrong hit or a wrong read value.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;
    localparam int NREG      = 4;
    localparam int IDXW      = $clog2(NREG);
    localparam int DW        = 32;
    localparam int SELW      = 12;
    localparam int TAGW      = 8;
    localparam logic [SELW-1:0] SEL_FIRST = 12'h004;
    localparam logic [DW-1:0]   KEEP_DATA  = 32'hFFFF_E464;
    localparam logic [DW-1:0]   KEEP_FETCH = 32'hFFFF_E460;

    typedef struct packed {
        logic [1:0] cmode;
        logic [1:0] smode;
        logic       amode;
        logic       wprot;
    } attr_t;

    typedef struct packed {
        logic [TAGW-1:0] base;
        logic [TAGW-1:0] mask;
        logic            en;
        attr_t           attr;
    } region_t;

    function automatic logic [DW-1:0] keep_bits(int idx);
        return (idx >= NREG / 2) ? KEEP_FETCH : KEEP_DATA;
    endfunction

    function automatic region_t decode(logic [DW-1:0] w);
        region_t r;
        r.base       = w[31:24];
        r.mask       = w[23:16];
        r.en         = w[15];
        r.attr.smode = w[14:13];
        r.attr.amode = w[10];
        r.attr.cmode = w[6:5];
        r.attr.wprot = w[2];
        return r;
    endfunction
endpackage

// File: rtl/region_reg_file.sv
module region_reg_file
    import region_attr_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SELW-1:0]          num,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output logic [NREG-1:0][DW-1:0]  words
);
    logic [SELW-1:0] offs;
    logic            valid;

    assign offs  = num - SEL_FIRST;
    assign valid = (num >= SEL_FIRST) && (offs < SELW'(NREG));

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (we && valid && offs[IDXW-1:0] == IDXW'(g))
                words[g] <= wdata & keep_bits(g);
        end
    end

    assign rdata = valid ? words[offs[IDXW-1:0]] : '0;
endmodule

// File: rtl/region_compare.sv
module region_compare
    import region_attr_pkg::*;
(
    input  logic [NREG-1:0][DW-1:0] words,
    input  logic [TAGW-1:0]         tag,
    output logic [NREG-1:0]         match
);
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        region_t r;
        assign r        = decode(words[g]);
        assign match[g] = r.en && (((tag ^ r.base) & ~r.mask) == '0);
    end
endmodule

// File: rtl/region_pick.sv
module region_pick
    import region_attr_pkg::*;
(
    input  logic [NREG-1:0] match,
    input  logic            is_fetch,
    output logic            found,
    output logic [IDXW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NREG - 1; k >= 0; k--) begin
            if (match[k] && ((k >= NREG / 2) == is_fetch)) begin
                found = 1'b1;
                idx   = IDXW'(k);
            end
        end
    end
endmodule

// File: rtl/region_attr_matcher.sv
module region_attr_matcher
    import region_attr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [11:0] reg_num,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_is_ifetch,
    output logic        hit,
    output logic [1:0]  hit_idx,
    output logic [1:0]  attr_cmode,
    output logic [1:0]  attr_smode,
    output logic        attr_amode,
    output logic        attr_wprot
);
    logic [NREG-1:0][DW-1:0] words;
    logic [NREG-1:0]         match;
    logic                    found;
    logic [IDXW-1:0]         idx;
    region_t                 win;
    attr_t                   attr;

    region_reg_file u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .num   (reg_num),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .words (words)
    );

    region_compare u_cmp (
        .words (words),
        .tag   (acc_addr[DW-1 -: TAGW]),
        .match (match)
    );

    region_pick u_pick (
        .match    (match),
        .is_fetch (acc_is_ifetch),
        .found    (found),
        .idx      (idx)
    );

    assign win  = decode(words[idx]);
    assign attr = found ? win.attr : '0;

    assign hit        = found;
    assign hit_idx    = found ? idx : '0;
    assign attr_cmode = attr.cmode;
    assign attr_smode = attr.smode;
    assign attr_amode = attr.amode;
    assign attr_wprot = attr.wprot;
endmodule

// File: rtl/region_attr_checker.sv
module region_attr_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [11:0] reg_num,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        acc_is_ifetch,
    input logic        hit,
    input logic [1:0]  hit_idx,
    input logic [1:0]  attr_cmode,
    input logic [1:0]  attr_smode,
    input logic        attr_amode,
    input logic        attr_wprot
);
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hit && reg_rdata == 32'h0));

    a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && $past(reg_num) == 12'h004 && reg_num == 12'h004)
        |-> reg_rdata == ($past(reg_wdata) & 32'hFFFF_E464));

    a_r6_pair_kind: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_idx[1] == acc_is_ifetch));

    a_r8_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_idx == 2'd0 && attr_cmode == 2'd0 && attr_smode == 2'd0
                  && !attr_amode && !attr_wprot));

    a_r10_fetch_no_wprot: assert property (@(posedge clk) disable iff (rst)
        acc_is_ifetch |-> !attr_wprot);
endmodule

bind region_attr_matcher region_attr_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .reg_num       (reg_num),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .acc_is_ifetch (acc_is_ifetch),
    .hit           (hit),
    .hit_idx       (hit_idx),
    .attr_cmode    (attr_cmode),
    .attr_smode    (attr_smode),
    .attr_amode    (attr_amode),
    .attr_wprot    (attr_wprot)
);

// File: tb/test_region_attr_matcher.sv
`timescale 1ns/1ps
module test_region_attr_matcher;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_num = 12'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_is_ifetch = 1'b0;
    logic        hit;
    logic [1:0]  hit_idx;
    logic [1:0]  attr_cmode;
    logic [1:0]  attr_smode;
    logic        attr_amode;
    logic        attr_wprot;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    region_attr_matcher i_region_attr_matcher (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_num(reg_num),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .acc_is_ifetch(acc_is_ifetch), .hit(hit), .hit_idx(hit_idx),
        .attr_cmode(attr_cmode), .attr_smode(attr_smode),
        .attr_amode(attr_amode), .attr_wprot(attr_wprot)
    );

    // Expected attributes per register as configured below: {cmode, smode, amode, wprot}
    localparam logic [5:0] ATTR_EXP [4] = '{
        {2'd1, 2'd2, 1'b0, 1'b1},
        {2'd3, 2'd0, 1'b1, 1'b0},
        {2'd2, 2'd1, 1'b0, 1'b0},
        {2'd0, 2'd3, 1'b0, 1'b0}
    };

    // {ifetch, addr[31:24], exp_hit, exp_idx}
    localparam logic [11:0] VEC [10] = '{
        {1'b0, 8'h10, 1'b1, 2'd0},   // R7 overlap, register 0 wins
        {1'b0, 8'h11, 1'b1, 2'd1},   // R4 masked bit 0
        {1'b0, 8'h50, 1'b1, 2'd1},   // R9 non-contiguous region
        {1'b0, 8'h51, 1'b1, 2'd1},   // R9
        {1'b0, 8'h12, 1'b0, 2'd0},   // R4 unmasked bit differs
        {1'b0, 8'h20, 1'b0, 2'd0},   // R6 fetch-only region, data access
        {1'b1, 8'h20, 1'b1, 2'd2},   // R7 overlap with register 3
        {1'b1, 8'h23, 1'b1, 2'd2},   // R4
        {1'b1, 8'h24, 1'b1, 2'd3},   // R6
        {1'b1, 8'h10, 1'b1, 2'd3}    // R6 data region not seen by fetch
    };

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] num, logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_num = num; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(string req, logic [11:0] num, logic [31:0] exp);
        reg_num = num;
        #1;
        chk(req, "rdata", reg_rdata, exp);
    endtask

    task automatic probe(string req, logic fetch, logic [31:0] addr, logic eh, logic [1:0] ei);
        logic [5:0] ea;
        acc_is_ifetch = fetch; acc_addr = addr;
        #1;
        ea = eh ? ATTR_EXP[ei] : 6'd0;
        chk(req, "hit", {31'd0, hit}, {31'd0, eh});
        chk(req, "idx", {30'd0, hit_idx}, {30'd0, (eh ? ei : 2'd0)});
        chk(req, "attrs", {26'd0, attr_cmode, attr_smode, attr_amode, attr_wprot}, {26'd0, ea});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 4; i++) rd("R1", 12'h004 + 12'(i), 32'h0);
        probe("R1", 1'b0, 32'h0000_0000, 1'b0, 2'd0);
        probe("R1", 1'b1, 32'h0000_0000, 1'b0, 2'd0);

        // R3 / R10 stored bits
        wr(12'h004, 32'hFFFF_FFFF);
        rd("R3", 12'h004, 32'hFFFF_E464);
        wr(12'h006, 32'hFFFF_FFFF);
        rd("R10", 12'h006, 32'hFFFF_E460);

        // configuration
        wr(12'h004, 32'h1000_C024);
        wr(12'h005, 32'h1041_8460);
        wr(12'h006, 32'h2003_A044);
        wr(12'h007, 32'h00FF_E000);
        rd("R2", 12'h004, 32'h1000_C024);
        rd("R2", 12'h005, 32'h1041_8460);
        rd("R10", 12'h006, 32'h2003_A040);
        rd("R2", 12'h007, 32'h00FF_E000);

        // R2 unassigned numbers
        wr(12'h003, 32'hFFFF_FFFF);
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF);
        rd("R2", 12'h003, 32'h0);
        rd("R2", 12'h008, 32'h0);
        rd("R2", 12'h004, 32'h1000_C024);
        rd("R2", 12'h007, 32'h00FF_E000);

        // table walk
        foreach (VEC[i]) begin
            probe("R8", VEC[i][11], {VEC[i][10:3], 24'hA5C3_5A}, VEC[i][2], VEC[i][1:0]);
        end
        probe("R4", 1'b0, 32'h10FF_FFFF, 1'b1, 2'd0);

        // R5 enable gating
        wr(12'h004, 32'h1000_4024);
        probe("R5", 1'b0, 32'h1000_0000, 1'b1, 2'd1);
        wr(12'h007, 32'h00FF_6000);
        probe("R5", 1'b1, 32'h2400_0000, 1'b0, 2'd0);
        probe("R5", 1'b1, 32'h2100_0000, 1'b1, 2'd2);

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd("R1", 12'h005, 32'h0);
        probe("R1", 1'b1, 32'h2000_0000, 1'b0, 2'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule